// File: doc/BRIEF.md
# Collision-Mode Wrapper for a Single-Clock Dual-Port RAM

This block places a simple dual-port synchronous RAM behind a wrapper. The RAM has one write port with per-byte write enables and one read port. Both ports run on one clock. The bare storage leaves the result undefined when a read and a write target the same word in the same cycle. In the model, the written lanes return a poison pattern. The wrapper adds a small bypass path so that such a collision resolves the way a build-time parameter asks for.

Three modes are available:

- **Read-first:** the read returns the word as it was before the write.
- **Write-first:** the read returns the word with the enabled lanes of the incoming write already merged in.
- **Undefined:** the raw storage result is passed through, with no extra logic.

Read data is registered. It changes only in a cycle where a read is requested, and it holds otherwise. Writes outside a collision are seen by every later read, in every mode.

Top module: `ram_collide_wrap`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_data` is zero until the first read is accepted.
- R2: A read with `rd_en` high at a clock edge shows, after that edge, the word last written to `rd_addr` in an earlier cycle.
- R3: A write updates only the byte lanes whose `wr_be` bit is set, where lane i is bits 8i+7 down to 8i. The other lanes keep their stored value.
- R4: While `rd_en` is low, `rd_data` keeps its value, whatever the write port does.
- R5: With MODE = 1 (write-first), a read and a full-mask write to the same address in one cycle return the write data.
- R6: With MODE = 1, in a same-address collision with a partial mask, the enabled lanes come from `wr_data` and the other lanes come from the stored word.
- R7: With MODE = 0 (read-first), a same-address collision returns the word as stored before that cycle's write.
- R8: With MODE = 0, a word written in one cycle is returned by a read of that address in the very next cycle.
- R9: With MODE = 2 (undefined), reads that do not collide behave as in R2 and R3. The collision result is not specified.
- R10: A write with `wr_be` equal to zero changes no stored lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the control and read registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data, four 8-bit lanes |
| wr_be | input | 4 | Per-lane write enables, bit i selects bits 8i+7:8i |
| rd_en | input | 1 | Read request, also the load enable of the read register |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Registered read data |

## Verification
A write and a read can land on the same word in the same cycle. This is the case the wrapper exists for. The bench provokes it by sweeping every address against all sixteen lane masks, with both ports aimed at one word in one step. It also follows each collision with a plain read, which shows what was actually stored. One instance of each mode receives the same stimulus. The expected word is merged lane by lane from a reference array in the bench: read-first expects the pre-write word and write-first expects the masked merge. Under the undefined mode, the colliding result is left unchecked until the next accepted read.

// File: rtl/colwrap_pkg.sv
// Package: shared collision-mode encoding for the RAM wrapper.
// Assumes: all wrapper modules import this encoding unchanged.
package colwrap_pkg;
    // Encoding is part of the interface: 0 read-first, 1 write-first, 2 undefined.
    typedef enum logic [1:0] {
        COL_READ_FIRST  = 2'd0,
        COL_WRITE_FIRST = 2'd1,
        COL_UNDEFINED   = 2'd2
    } col_mode_e;
endpackage

// File: rtl/cw_storage.sv
// Module: bare simple dual-port storage with per-lane write enables and a
// one-cycle registered read. A read that meets a write to the same word in
// the same cycle returns POISON in every lane being written (undefined result).
// Assumes: one clock; the array itself is not reset.
module cw_storage #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter logic [LANE_W-1:0] POISON = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          wbe,
    input  logic                      re,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              same_word;

    assign same_word = we && (waddr == raddr);

    // Write the enabled lanes of the addressed word.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && wbe[l])
                mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    // Load the read register; colliding written lanes come back poisoned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            for (int l = 0; l < LANES; l++) begin
                if (same_word && wbe[l])
                    rdata[l*LANE_W +: LANE_W] <= POISON;
                else
                    rdata[l*LANE_W +: LANE_W] <= mem[raddr][l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/cw_write_stage.sv
// Module: shapes the write that reaches the storage and the bypass source.
// Read-first: every write is held one cycle, so a same-cycle read still sees
// the old word and the held write is forwarded to later reads.
// Other modes: the write passes straight through.
// Assumes: the mode is fixed at build time.
module cw_write_stage #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter colwrap_pkg::col_mode_e MODE = colwrap_pkg::COL_WRITE_FIRST
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_en,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic [LANES*LANE_W-1:0]   in_data,
    input  logic [LANES-1:0]          in_be,
    output logic                      out_en,
    output logic [ADDR_W-1:0]         out_addr,
    output logic [LANES*LANE_W-1:0]   out_data,
    output logic [LANES-1:0]          out_be
);
    localparam bit DEFER  = (MODE == colwrap_pkg::COL_READ_FIRST);
    localparam int DATA_W = LANES * LANE_W;

    logic              hold_en;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic [LANES-1:0]  hold_be;

    // Capture the incoming write for one cycle of deferral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_en   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            hold_be   <= '0;
        end else begin
            hold_en   <= in_en;
            hold_addr <= in_addr;
            hold_data <= in_data;
            hold_be   <= in_be;
        end
    end

    // Choose deferred or direct write according to the mode.
    always_comb begin
        out_en   = DEFER ? hold_en   : in_en;
        out_addr = DEFER ? hold_addr : in_addr;
        out_data = DEFER ? hold_data : in_data;
        out_be   = DEFER ? hold_be   : in_be;
    end
endmodule

// File: rtl/cw_fwd_merge.sv
// Module: bypass path. When a read hits the word being written by the
// source write, it registers a per-lane hit mask and the source data, then
// overrides those lanes of the raw storage result in the following cycle.
// Assumes: raw comes from a register loaded under the same read enable.
module cw_fwd_merge #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter colwrap_pkg::col_mode_e MODE = colwrap_pkg::COL_WRITE_FIRST
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      src_en,
    input  logic [ADDR_W-1:0]         src_addr,
    input  logic [LANES*LANE_W-1:0]   src_data,
    input  logic [LANES-1:0]          src_be,
    input  logic [LANES*LANE_W-1:0]   raw,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam bit BYPASS = (MODE != colwrap_pkg::COL_UNDEFINED);
    localparam int DATA_W = LANES * LANE_W;

    logic              hit_now;
    logic [LANES-1:0]  lane_hit;
    logic [DATA_W-1:0] fwd_data;

    assign hit_now = BYPASS && src_en && (src_addr == rd_addr);

    // Record which lanes to override, only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_hit <= '0;
            fwd_data <= '0;
        end else if (rd_en) begin
            lane_hit <= hit_now ? src_be : '0;
            fwd_data <= src_data;
        end
    end

    // Per-lane select between forwarded and stored data.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_data[g*LANE_W +: LANE_W] =
            lane_hit[g] ? fwd_data[g*LANE_W +: LANE_W] : raw[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ram_collide_wrap.sv
// Module: top of the collision-mode wrapper. Joins the write stage, the
// bare storage and the bypass merge. MODE 0 read-first, 1 write-first,
// 2 undefined collision.
// Assumes: one clock for both ports; 32-bit words in four 8-bit lanes.
module ram_collide_wrap #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter colwrap_pkg::col_mode_e MODE = colwrap_pkg::COL_WRITE_FIRST
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [LANES-1:0]          wr_be,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DATA_W = LANES * LANE_W;

    logic              st_en;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] raw_q;

    cw_write_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .MODE(MODE)) u_wstage (
        .clk(clk), .rst_n(rst_n),
        .in_en(wr_en), .in_addr(wr_addr), .in_data(wr_data), .in_be(wr_be),
        .out_en(st_en), .out_addr(st_addr), .out_data(st_data), .out_be(st_be)
    );

    cw_storage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_en), .waddr(st_addr), .wdata(st_data), .wbe(st_be),
        .re(rd_en), .raddr(rd_addr), .rdata(raw_q)
    );

    cw_fwd_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .MODE(MODE)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .src_en(st_en), .src_addr(st_addr), .src_data(st_data), .src_be(st_be),
        .raw(raw_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/cw_checker.sv
// Module: assertion checker for ram_collide_wrap, attached by bind.
// Assumes: it observes only the top-level ports.
module cw_checker #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter colwrap_pkg::col_mode_e MODE = colwrap_pkg::COL_WRITE_FIRST
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [LANES*LANE_W-1:0]   wr_data,
    input logic [LANES-1:0]          wr_be,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         rd_addr,
    input logic [LANES*LANE_W-1:0]   rd_data
);
    localparam bit IS_WF = (MODE == colwrap_pkg::COL_WRITE_FIRST);

    logic [LANES*LANE_W-1:0] be_bits;
    for (genvar g = 0; g < LANES; g++) begin : g_be
        assign be_bits[g*LANE_W +: LANE_W] = {LANE_W{wr_be[g]}};
    end

    // R1: read data is zero on leaving reset
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0));

    // R4: output holds while no read is accepted
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5: full-mask collision in write-first mode returns the write data
    p_wf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_WF && rd_en && wr_en && wr_addr == rd_addr && (&wr_be))
        |=> (rd_data == $past(wr_data)));

    // R6: enabled lanes of a write-first collision come from the write data
    p_wf_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_WF && rd_en && wr_en && wr_addr == rd_addr)
        |=> ((rd_data & $past(be_bits)) == ($past(wr_data) & $past(be_bits))));
endmodule

bind ram_collide_wrap cw_checker #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .MODE(MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
);

// File: tb/ram_collide_wrap_tb.sv
// Bench: one instance per collision mode on shared stimulus; expected words
// are merged lane by lane from a reference array kept in the bench.
module ram_collide_wrap_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_be = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   q_wf, q_rf, q_ud;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ref_mem [DEPTH];
    logic [31:0] exp_wf = '0, exp_rf = '0, exp_ud = '0;
    bit          ud_known = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_collide_wrap #(.ADDR_W(AW), .MODE(colwrap_pkg::COL_WRITE_FIRST)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_wf));
    ram_collide_wrap #(.ADDR_W(AW), .MODE(colwrap_pkg::COL_READ_FIRST)) u_dut_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_rf));
    ram_collide_wrap #(.ADDR_W(AW), .MODE(colwrap_pkg::COL_UNDEFINED)) u_dut_ud (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_ud));

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++)
            if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, pass a rising edge, check at the next falling edge.
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [31:0] wd,
                        input logic [3:0] be, input logic re, input logic [AW-1:0] ra,
                        input string t_wf, input string t_rf, input string t_ud);
        bit coll;
        wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be;
        rd_en = re; rd_addr = ra;
        coll = we && (wa == ra);
        if (re) begin
            exp_rf = ref_mem[ra];
            exp_wf = coll ? merge(ref_mem[ra], wd, be) : ref_mem[ra];
            if (coll) ud_known = 1'b0;
            else begin ud_known = 1'b1; exp_ud = ref_mem[ra]; end
        end
        if (we) ref_mem[wa] = merge(ref_mem[wa], wd, be);
        @(negedge clk);
        check(t_wf, q_wf, exp_wf);
        check(t_rf, q_rf, exp_rf);
        if (ud_known) check(t_ud, q_ud, exp_ud);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, held in reset and just after release
        check("R1 wf in reset", q_wf, 32'h0);
        check("R1 rf in reset", q_rf, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ud after release", q_ud, 32'h0);

        // Fill every word; no read, so outputs must stay zero (R4, R1).
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, AW'(a), 32'hC3A50000 ^ (32'(a) * 32'h01010101), 4'hF, 1'b0, '0,
                 "R4 wf hold", "R4 rf hold", "R1 ud zero");

        // R2: plain reads of every word.
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, '0, '0, 4'h0, 1'b1, AW'(a), "R2 wf read", "R2 rf read", "R9 ud read");

        // R3/R8/R10: masked write, then read the same word in the next cycle.
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < 16; b++) begin
                step(1'b1, AW'(a), 32'h11223344 * 32'(b + 3 + a), 4'(b), 1'b0, '0,
                     "R4 wf hold", "R4 rf hold", "R4 ud hold");
                step(1'b0, '0, '0, 4'h0, 1'b1, AW'(a),
                     (b == 0) ? "R10 wf no-lane write" : "R3 wf lanes",
                     "R8 rf back-to-back", "R9 ud lanes");
            end

        // R5/R6/R7: same-word collision for every mask, then a confirming read.
        for (int a = 0; a < DEPTH; a++)
            for (int b = 0; b < 16; b++) begin
                step(1'b1, AW'(a), 32'h9E3779B9 ^ (32'(b) << 8) ^ 32'(a), 4'(b), 1'b1, AW'(a),
                     (b == 15) ? "R5 wf full collision" : "R6 wf partial collision",
                     "R7 rf collision", "R9 ud collision");
                step(1'b0, '0, '0, 4'h0, 1'b1, AW'(a), "R3 wf stored", "R3 rf stored",
                     "R9 ud stored");
            end

        // Collision of a write with a read of a different word.
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, AW'(a), 32'h0BADF00D + 32'(a), 4'hF, 1'b1, AW'((a + 1) % DEPTH),
                 "R2 wf other word", "R2 rf other word", "R9 ud other word");

        // R4: writes to the last read word with no read must not move the output.
        for (int b = 0; b < 4; b++)
            step(1'b1, AW'(DEPTH - 1), 32'hFFFF0000 + 32'(b), 4'hF, 1'b0, '0,
                 "R4 wf hold", "R4 rf hold", "R4 ud hold");
        step(1'b0, '0, '0, 4'h0, 1'b1, AW'(DEPTH - 1), "R2 wf final", "R2 rf final",
             "R9 ud final");

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule